// File: doc/BRIEF.md
# Flash Auto-Erase Sequencer

This block is the erase engine inside a NOR-style flash model. Once a command front end has accepted an erase, it pulses `start` with a mode flag. The flag picks either the whole array or a bitmap of chosen blocks. The engine then works through every targeted block that is not write-protected, in rising block-index order. Each such block gets three passes: it writes zero into every word, then writes all-ones into every word, then reads every word back and checks that it is all-ones. The host sees a status nibble: a busy bit, a bit that flips on each status read while busy, an error bit and a suspended bit.

Some requests target only protected blocks. These perform no write, and the engine simply stays busy for a fixed hold time (`HOLD_CYC` cycles). A failed read-back leaves the engine parked in an error state. The status does not identify the failing block, and only a reset command or the hardware reset clears the state. The hardware reset stops the engine at once in any phase and leaves the array exactly as far as the passes got. The array is a single-port word memory that can map to block RAM. While the engine is idle, the array can be read through a registered read port. A fault-injection input forces the read-back of one chosen block to miscompare.

Top module: `flash_erase_seq`

## Requirements
- R1: A `start` pulse sampled while idle, with `chip_mode`=0, erases each block whose `blk_sel` bit is 1 and whose `blk_prot` bit is 0. Every word of each such block reads 0xFF once busy (`stat[0]`) drops.
- R2: Each erased block first has every word written to 0x00, and only after that is every word written to 0xFF. A block interrupted after its zero pass and partway into its ones pass reads 0xFF in the words already reached and 0x00 in the rest.
- R3: A block whose `blk_prot` bit is 1 at `start` is never written. Its words keep their previous values.
- R4: If no targeted block is unprotected, no word is written. `stat[0]` is 1 for exactly `HOLD_CYC` cycles and then returns to 0.
- R5: Blocks are processed in ascending index order. A failed read-back stops the sequence, so blocks with higher indices stay unwritten.
- R6: A failed read-back (a word not equal to 0xFF, or `fault_en`=1 with `fault_blk` equal to the block) sets `stat[2]`=1 with `stat[0]`=1. This state is held against every command except the reset command 0xF0, which returns the engine to idle.
- R7: `rst`=1 returns the engine to idle at the next clock edge with `stat` cleared, whatever the phase. It leaves the array partially erased, and a new `start` completes the erase.
- R8: With `chip_mode`=1, every unprotected block is erased whatever `blk_sel` holds. The suspend command 0xB0 is ignored, so `stat[3]` stays 0.
- R9: During a block-mode erase, command 0xB0 halts the sequence and sets `stat[3]`=1 with `stat[0]`=1. Command 0x30 resumes the sequence, restarting the current pass at word 0, and the erase then completes.
- R10: Each cycle with `status_rd`=1 while busy flips `stat[1]`. Without `status_rd`, or while idle, `stat[1]` holds.
- R11: A `start` pulse while busy is ignored, and the blocks it names are not written.
- R12: While idle, `rd_data` shows the word at `rd_addr` (block index in the upper bits, word index in the lower) one cycle later. The power-up content of flat word address a is a XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| start | input | 1 | Erase start strobe, sampled while idle |
| chip_mode | input | 1 | 1 = whole array, 0 = blocks in blk_sel |
| blk_sel | input | N_BLK | Selected-block bitmap for block mode |
| blk_prot | input | N_BLK | Per-block write-protect bitmap |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte: 0xF0 reset, 0xB0 suspend, 0x30 resume |
| status_rd | input | 1 | Status read strobe |
| fault_en | input | 1 | Enable forced read-back miscompare |
| fault_blk | input | $clog2(N_BLK) | Block whose read-back is forced to fail |
| rd_addr | input | $clog2(N_BLK*WORDS) | Array read address |
| rd_data | output | DW | Array read data, one cycle latency |
| stat | output | 4 | {suspended, error, toggle, busy} |

## Verification
The bench resets the engine one phase after the zero pass of a block. It expects an exact split of 0xFF and 0x00 words, which exposes a design that skips the zero pass or that fails to stop on reset. It injects a read-back fault in the middle of a multi-block request. If the design ignores the fault or walks blocks out of order, the error bit stays low or the next block gets erased. It sends suspend in chip mode, where the command must be ignored, and in block mode, where it must halt the engine. It issues `start` while busy and checks that the block it names is left alone. A sweep over both modes, several protection masks and every selection bitmap tracks the whole array. In that sweep it times the busy window for requests that target only protected blocks, which catches a wrong hold count or a stray write.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_SCAN, S_PRE, S_ERS, S_VFY, S_SUSP, S_FAIL
  } fes_state_t;

  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;

  localparam logic [7:0] INIT_XOR   = 8'hA5;
endpackage

// File: rtl/fes_mem.sv
`timescale 1ns/1ps
module fes_mem #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      arr[a] = DW'(a) ^ DW'(fes_pkg::INIT_XOR);
    end
  end

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
    rdata <= arr[addr];
  end
endmodule

// File: rtl/fes_pick.sv
`timescale 1ns/1ps
module fes_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |pend;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fes_status.sv
`timescale 1ns/1ps
module fes_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy_i,
  input  logic       err_i,
  input  logic       susp_i,
  input  logic       status_rd,
  output logic [3:0] stat
);
  logic tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog  <= 1'b0;
      stat <= '0;
    end else begin
      if (status_rd && busy_i) tog <= ~tog;
      stat <= {susp_i, err_i, (status_rd && busy_i) ? ~tog : tog, busy_i};
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int N_BLK    = 4,
  parameter int WORDS    = 8,
  parameter int DW       = 8,
  parameter int HOLD_CYC = 20000
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             chip_mode,
  input  logic [N_BLK-1:0]                 blk_sel,
  input  logic [N_BLK-1:0]                 blk_prot,
  input  logic                             cmd_valid,
  input  logic [7:0]                       cmd_code,
  input  logic                             status_rd,
  input  logic                             fault_en,
  input  logic [$clog2(N_BLK)-1:0]         fault_blk,
  input  logic [$clog2(N_BLK*WORDS)-1:0]   rd_addr,
  output logic [DW-1:0]                    rd_data,
  output logic [3:0]                       stat
);
  localparam int IW = $clog2(N_BLK);
  localparam int WW = $clog2(WORDS);
  localparam int AW = IW + WW;
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [WW-1:0] WMAX = WW'(WORDS - 1);

  fes_state_t       state, sus_ret;
  logic [N_BLK-1:0] pend, prot_q, tgt_pend;
  logic             chip_q;
  logic [IW-1:0]    cur, pick_idx, mem_blk;
  logic [WW-1:0]    widx;
  logic             vq_valid, vq_last, iss_done;
  logic [CW-1:0]    wait_cnt;
  logic             pick_found, susp_req, miscmp, fault_hit;
  logic             mem_we;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata, mem_rdata;
  logic             st_fail, st_susp;

  // Target set: whole array or selected blocks, minus protected ones.
  assign tgt_pend  = (chip_mode ? {N_BLK{1'b1}} : blk_sel) & ~blk_prot;
  assign susp_req  = cmd_valid && (cmd_code == CMD_SUSP) && !chip_q;
  assign fault_hit = fault_en && (fault_blk == cur);
  assign miscmp    = (mem_rdata != {DW{1'b1}}) || fault_hit;

  assign mem_we    = (state == S_PRE) || (state == S_ERS);
  assign mem_wdata = (state == S_ERS) ? {DW{1'b1}} : '0;
  assign mem_addr  = (state == S_IDLE) ? rd_addr : {cur, widx};
  assign mem_blk   = mem_addr[AW-1:WW];
  assign rd_data   = mem_rdata;
  assign st_fail   = (state == S_FAIL);
  assign st_susp   = (state == S_SUSP);

  fes_pick #(.N(N_BLK), .IW(IW)) u_pick (
    .pend  (pend),
    .found (pick_found),
    .idx   (pick_idx)
  );

  fes_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  fes_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (state != S_IDLE),
    .err_i     (st_fail),
    .susp_i    (st_susp),
    .status_rd (status_rd),
    .stat      (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      sus_ret  <= S_PRE;
      pend     <= '0;
      prot_q   <= '0;
      chip_q   <= 1'b0;
      cur      <= '0;
      widx     <= '0;
      vq_valid <= 1'b0;
      vq_last  <= 1'b0;
      iss_done <= 1'b0;
      wait_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            chip_q <= chip_mode;
            prot_q <= blk_prot;
            pend   <= tgt_pend;
            if (tgt_pend == '0) begin
              wait_cnt <= CW'(HOLD_CYC - 1);
              state    <= S_HOLD;
            end else begin
              state <= S_SCAN;
            end
          end
        end
        S_HOLD: begin
          if (wait_cnt == '0) state <= S_IDLE;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        S_SCAN: begin
          if (pick_found) begin
            cur   <= pick_idx;
            widx  <= '0;
            state <= S_PRE;
          end else begin
            state <= S_IDLE;
          end
        end
        S_PRE, S_ERS: begin
          if (susp_req) begin
            sus_ret <= state;
            state   <= S_SUSP;
          end else begin
            widx <= widx + 1'b1;
            if (widx == WMAX) begin
              widx     <= '0;
              iss_done <= 1'b0;
              vq_valid <= 1'b0;
              state    <= (state == S_PRE) ? S_ERS : S_VFY;
            end
          end
        end
        S_VFY: begin
          if (susp_req) begin
            sus_ret  <= S_VFY;
            vq_valid <= 1'b0;
            state    <= S_SUSP;
          end else begin
            if (!iss_done) begin
              vq_valid <= 1'b1;
              vq_last  <= (widx == WMAX);
              if (widx == WMAX) iss_done <= 1'b1;
              else widx <= widx + 1'b1;
            end else begin
              vq_valid <= 1'b0;
            end
            if (vq_valid) begin
              if (miscmp) begin
                state <= S_FAIL;
              end else if (vq_last) begin
                pend[cur] <= 1'b0;
                state     <= S_SCAN;
              end
            end
          end
        end
        S_SUSP: begin
          if (cmd_valid && (cmd_code == CMD_RESUME)) begin
            state    <= sus_ret;
            widx     <= '0;
            iss_done <= 1'b0;
            vq_valid <= 1'b0;
          end
        end
        S_FAIL: begin
          vq_valid <= 1'b0;
          if (cmd_valid && (cmd_code == CMD_RESET)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fes_chk.sv
`timescale 1ns/1ps
module fes_chk #(
  parameter int N_BLK = 4,
  parameter int IW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             status_rd,
  input logic             cmd_valid,
  input logic [7:0]       cmd_code,
  input logic [3:0]       stat,
  input logic             mem_we,
  input logic [IW-1:0]    mem_blk,
  input logic [N_BLK-1:0] prot_q,
  input logic             chip_q,
  input logic             st_fail,
  input logic             st_susp
);
  // R3: no write lands in a block latched as protected
  a_r3_no_prot_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !prot_q[mem_blk]);

  // R6: failure state held unless the reset command arrives
  a_r6_fail_holds: assert property (@(posedge clk) disable iff (rst)
    (st_fail && !(cmd_valid && cmd_code == 8'hF0)) |=> st_fail);

  // R6: error flag only ever shown together with busy
  a_r6_err_busy: assert property (@(posedge clk) disable iff (rst)
    stat[2] |-> stat[0]);

  // R7: hardware reset clears status on the next edge
  a_r7_rst_idle: assert property (@(posedge clk)
    rst |=> (stat == 4'b0000));

  // R8: suspension never entered in chip mode
  a_r8_no_chip_susp: assert property (@(posedge clk) disable iff (rst)
    st_susp |-> !chip_q);

  // R9: suspended flag implies busy
  a_r9_susp_busy: assert property (@(posedge clk) disable iff (rst)
    stat[3] |-> stat[0]);

  // R10: toggle bit moves only on a status read
  a_r10_toggle_stable: assert property (@(posedge clk) disable iff (rst)
    !status_rd |=> $stable(stat[1]));
endmodule

bind flash_erase_seq fes_chk #(.N_BLK(N_BLK), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .status_rd (status_rd),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .stat      (stat),
  .mem_we    (mem_we),
  .mem_blk   (mem_blk),
  .prot_q    (prot_q),
  .chip_q    (chip_q),
  .st_fail   (st_fail),
  .st_susp   (st_susp)
);

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;
  localparam int N_BLK = 4;
  localparam int WORDS = 8;
  localparam int DW    = 8;
  localparam int HOLD  = 40;
  localparam int NW    = N_BLK * WORDS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, chip_mode = 1'b0;
  logic [3:0] blk_sel = '0, blk_prot = '0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       status_rd = 1'b0, fault_en = 1'b0;
  logic [1:0] fault_blk = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] stat;

  int tests = 0, fails = 0;
  logic [7:0] expm [NW];

  always #2.5 clk = ~clk;

  flash_erase_seq #(.N_BLK(N_BLK), .WORDS(WORDS), .DW(DW), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst(rst), .start(start), .chip_mode(chip_mode),
    .blk_sel(blk_sel), .blk_prot(blk_prot), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .status_rd(status_rd), .fault_en(fault_en),
    .fault_blk(fault_blk), .rd_addr(rd_addr), .rd_data(rd_data), .stat(stat)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic blk_check(string req, int b);
    int bad = 0;
    for (int w = 0; w < WORDS; w++) begin
      rd_addr = 5'(b * WORDS + w);
      tick();
      if (rd_data != expm[b * WORDS + w]) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic go(logic chip, logic [3:0] sel, logic [3:0] prot);
    chip_mode = chip; blk_sel = sel; blk_prot = prot; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic cmd(logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    tick(); tick();
    while (stat[0] && n < 3000) begin tick(); n++; end
    check(req, int'(stat[0]), 0);
  endtask

  task automatic mark(int b, logic [7:0] v);
    for (int w = 0; w < WORDS; w++) expm[b * WORDS + w] = v;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0, n;
    for (int a = 0; a < NW; a++) expm[a] = 8'(a) ^ 8'hA5;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    check("R7 reset status", int'(stat), 0);
    blk_check("R12 power-up pattern blk3", 3);

    // R8: chip mode ignores blk_sel, protected blocks 0 and 2 kept
    go(1'b1, 4'b0000, 4'b0101);
    tick(); tick();
    t0 = int'(stat[1]);
    for (int i = 0; i < 4; i++) begin
      status_rd = 1'b1; tick(); status_rd = 1'b0; tick();
      check("R10 toggle flips while busy", int'(stat[1]), t0 ^ ((i + 1) & 1));
    end
    cmd(8'hB0); tick();
    check("R8 suspend ignored in chip mode", int'(stat[3]), 0);
    wait_idle("R8 chip erase ends");
    mark(1, 8'hFF); mark(3, 8'hFF);
    for (int b = 0; b < N_BLK; b++) blk_check("R8 R3 chip erase contents", b);
    t0 = int'(stat[1]);
    status_rd = 1'b1; tick(); status_rd = 1'b0; tick();
    check("R10 toggle holds while idle", int'(stat[1]), t0);

    // R2/R7: hardware reset in the ones pass of block 0
    go(1'b0, 4'b0001, 4'b0000);
    repeat (12) tick();
    rst = 1'b1; tick(); rst = 1'b0;
    check("R7 busy cleared by reset", int'(stat), 0);
    for (int w = 0; w < WORDS; w++) expm[w] = (w < 4) ? 8'hFF : 8'h00;
    blk_check("R2 R7 partial erase left", 0);

    // R7 re-erase, R11 start while busy names block 2
    go(1'b0, 4'b0001, 4'b0000);
    tick(); tick(); tick();
    go(1'b0, 4'b0100, 4'b0000);
    wait_idle("R7 re-erase ends");
    mark(0, 8'hFF);
    blk_check("R7 re-erase completes", 0);
    blk_check("R11 start while busy ignored", 2);

    // R5/R6: fault on block 1, block 2 must stay untouched
    fault_en = 1'b1; fault_blk = 2'd1;
    go(1'b0, 4'b0111, 4'b0000);
    n = 0;
    while (!stat[2] && n < 1000) begin tick(); n++; end
    check("R6 error set", int'(stat[2:0] & 3'b101), 5);
    cmd(8'hB0); cmd(8'h30); repeat (5) tick();
    check("R6 error held against other commands", int'(stat[2:0] & 3'b101), 5);
    cmd(8'hF0); tick(); tick();
    check("R6 reset command clears", int'(stat), 0);
    fault_en = 1'b0;
    blk_check("R5 R6 block before fault erased", 1);
    blk_check("R5 later block untouched", 2);

    // R9: suspend in block mode on block 2
    go(1'b0, 4'b0100, 4'b0000);
    repeat (6) tick();
    cmd(8'hB0); tick();
    check("R9 suspended flag", int'(stat[3] & stat[0]), 1);
    repeat (200) tick();
    check("R9 halted while suspended", int'(stat[3] & stat[0]), 1);
    cmd(8'h30); tick();
    check("R9 resumed", int'(stat[3]), 0);
    wait_idle("R9 erase ends after resume");
    mark(2, 8'hFF);
    blk_check("R9 block erased after resume", 2);

    // Sweep: both modes, protect masks, every selection
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s < 16; s++) begin
          logic [3:0] pm, tg;
          pm = (p == 0) ? 4'h0 : (p == 1) ? 4'h3 : (p == 2) ? 4'h5 : 4'hF;
          tg = ((c == 1) ? 4'hF : 4'(s)) & ~pm;
          go(c[0], 4'(s), pm);
          if (tg == 4'h0) begin
            n = 0;
            for (int k = 0; k < HOLD + 10; k++) begin
              tick();
              if (stat[0]) n++;
            end
            check("R4 hold length when all protected", n, HOLD);
          end else begin
            wait_idle("R1 sweep erase ends");
          end
          for (int b = 0; b < N_BLK; b++) if (tg[b]) mark(b, 8'hFF);
          for (int b = 0; b < N_BLK; b++) blk_check("R1 R3 R4 sweep contents", b);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule